// File: doc/BRIEF.md
# Triggered ADC Conversion Sequencer

This block sits between an external trigger source and a successive-approximation converter. It accepts a conversion command, which is a trigger strobe carrying a channel number. For each command it models how long the conversion takes: it counts an overhead phase, a sampling window of programmable length and fourteen approximation steps of four cycles each. All counting is in conversion-clock cycles. The conversion clock is either the bus clock itself or the bus clock divided by two. While a conversion runs, `busy` is high. When it ends, `done` pulses for one cycle and `result` presents a placeholder value, which is the channel number zero-extended.

A command that arrives in the same cycle that the running conversion completes is chained. It starts at once and is one cycle shorter than a first conversion. A command that arrives earlier is dropped, and it raises a sticky overrun flag. A single control register holds three things: a power-down bit, a clock-select bit and the sampling length. The clock-select bit is locked except while the block is powered down. While powered down, the block runs no conversion and ignores triggers.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, `busy`, `done` and `overrun` are 0. `cfg_q` reads power-down = 1, clock select = 0 and sampling length = 22.
- R2: Control layout for `cfg_wdata`/`cfg_q`: bit 0 is power-down, bit 1 is clock select and bits [9:2] are the sampling length S. A command accepted while idle keeps `busy` high for (S + 60) conversion-clock cycles, which is 82 cycles for S = 22.
- R3: A command presented in the last busy cycle of a conversion is accepted. It runs (S + 59) conversion-clock cycles, and `busy` stays high across the boundary.
- R4: A command presented while busy, in any cycle except the last, is dropped. It sets `overrun` in the following cycle, and the running conversion finishes unchanged.
- R5: `overrun` stays 1 until `ovr_clr` is pulsed. It is 0 in the cycle after the clear.
- R6: Each completed conversion produces exactly one single-cycle `done` pulse, in the cycle after its last busy cycle. `result` then equals the command's channel.
- R7: A write to the clock-select bit takes effect only if the stored power-down bit is 1 in the write cycle. Otherwise the bit keeps its value. The power-down bit and the sampling length are always written.
- R8: With clock select = 1, a conversion-clock cycle equals one bus cycle. With clock select = 0, it equals two bus cycles, so every busy period doubles.
- R9: While power-down is 1, triggers start nothing and do not set `overrun`, and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 10 | Control write data |
| cfg_q | output | 10 | Stored control register |
| ovr_clr | input | 1 | Clear pulse for the overrun flag |
| trig_valid | input | 1 | Conversion command strobe |
| trig_chan | input | 5 | Channel of the command |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Placeholder result (channel number) |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest situation to reach is the exact completion cycle. A trigger that lands there must chain with the shorter length, while a trigger one cycle earlier must overrun. This cycle is not visible at the ports until it has passed. The stimulus therefore counts from the accepting edge, using the length the requirements give for each clock mode and sampling setting. It places the second trigger on the final busy cycle for chained vectors and one cycle before it for overrun vectors, in both clock modes. The locked clock-select bit is reached by writing it once while powered up and once in the cycle that power-down is first set.

// File: rtl/adc_seq_pkg.sv
// Package: shared widths and the control register layout of the sequencer.
// Assumes the sampling field fits in SAMP_W bits; widths derive from it.
package adc_seq_pkg;
    parameter int unsigned SAMP_W = 8;
    localparam int unsigned CFG_W = SAMP_W + 2;

    typedef struct packed {
        logic [SAMP_W-1:0] samp;
        logic              clk_full;
        logic              pwr_dn;
    } ctrl_t;
endpackage

// File: rtl/adc_ctrl_reg.sv
// Control register: power-down, clock select and sampling length.
// Assumes writes are single-cycle strobes; clock select is locked unless
// the stored power-down bit is set in the cycle of the write.
module adc_ctrl_reg
    import adc_seq_pkg::*;
#(
    parameter int unsigned SAMP_RST = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output ctrl_t            ctrl
);
    ctrl_t ctrl_q;
    ctrl_t wr;

    assign wr   = ctrl_t'(wdata);
    assign ctrl = ctrl_q;

    // Register update with clock-select lock outside power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.pwr_dn   <= 1'b1;
            ctrl_q.clk_full <= 1'b0;
            ctrl_q.samp     <= SAMP_W'(SAMP_RST);
        end else if (we) begin
            ctrl_q.pwr_dn <= wr.pwr_dn;
            ctrl_q.samp   <= wr.samp;
            if (ctrl_q.pwr_dn) begin
                ctrl_q.clk_full <= wr.clk_full;
            end
        end
    end
endmodule

// File: rtl/adc_clk_tick.sv
// Conversion-clock enable: every bus cycle in full mode, every second bus
// cycle in half mode. Phase restarts on each accepted command so lengths
// are exact multiples of the divider.
module adc_clk_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic full,
    input  logic run,
    input  logic restart,
    output logic tick
);
    logic div_q;

    // Divider phase toggles only while a conversion runs.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            div_q <= 1'b0;
        end else begin
            div_q <= ~div_q;
        end
    end

    assign tick = full | div_q;
endmodule

// File: rtl/adc_conv_fsm.sv
// Conversion timing engine: loads a length on acceptance, counts it down
// in conversion-clock ticks, chains commands arriving in the completion
// cycle with the shorter length and flags early commands as overrun.
// Assumes the length fits in the counter derived from SAMP_W.
module adc_conv_fsm
    import adc_seq_pkg::*;
#(
    parameter int unsigned CH_W      = 5,
    parameter int unsigned RES_W     = 12,
    parameter int unsigned SAR_STEPS = 13,
    parameter int unsigned STEP_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic             tick,
    input  logic             trig_valid,
    input  logic [CH_W-1:0]  trig_chan,
    input  logic             ovr_clr,
    output logic             restart,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             overrun
);
    localparam int unsigned CONV_CYC  = (SAR_STEPS + 1) * STEP_CYC;
    localparam int unsigned OVH_FIRST = 4 + CONV_CYC;
    localparam int unsigned OVH_NEXT  = 3 + CONV_CYC;
    localparam int unsigned MAX_LEN   = (2 ** SAMP_W) - 1 + OVH_FIRST;
    localparam int unsigned LEN_W     = $clog2(MAX_LEN + 1);

    logic             busy_q, done_q, ovr_q;
    logic [LEN_W-1:0] cnt_q;
    logic [CH_W-1:0]  chan_q;
    logic [RES_W-1:0] res_q;
    logic             fin, accept, early;
    logic [LEN_W-1:0] len_first, len_next;

    assign len_first = LEN_W'(ctrl.samp) + LEN_W'(OVH_FIRST);
    assign len_next  = LEN_W'(ctrl.samp) + LEN_W'(OVH_NEXT);
    assign fin       = busy_q & tick & (cnt_q == LEN_W'(1));
    assign accept    = trig_valid & ~ctrl.pwr_dn & (~busy_q | fin);
    assign early     = trig_valid & ~ctrl.pwr_dn & busy_q & ~fin;
    assign restart   = accept;

    // Conversion state: start, chain, count down, complete or abort.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl.pwr_dn) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            chan_q <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= fin ? len_next : len_first;
            chan_q <= trig_chan;
        end else if (fin) begin
            busy_q <= 1'b0;
        end else if (busy_q && tick) begin
            cnt_q <= cnt_q - LEN_W'(1);
        end
    end

    // Completion pulse and placeholder result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= fin & ~ctrl.pwr_dn;
            if (fin && !ctrl.pwr_dn) begin
                res_q <= RES_W'(chan_q);
            end
        end
    end

    // Sticky overrun: set wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (early) begin
            ovr_q <= 1'b1;
        end else if (ovr_clr) begin
            ovr_q <= 1'b0;
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign result  = res_q;
    assign overrun = ovr_q;
endmodule

// File: rtl/adc_conv_sequencer.sv
// Top level: control register, conversion-clock enable and timing engine.
// Assumes triggers and control writes are synchronous to clk.
module adc_conv_sequencer
    import adc_seq_pkg::*;
#(
    parameter int unsigned CH_W      = 5,
    parameter int unsigned RES_W     = 12,
    parameter int unsigned SAMP_RST  = 22,
    parameter int unsigned SAR_STEPS = 13,
    parameter int unsigned STEP_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_q,
    input  logic             ovr_clr,
    input  logic             trig_valid,
    input  logic [CH_W-1:0]  trig_chan,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             overrun
);
    ctrl_t ctrl;
    logic  tick, restart;

    assign cfg_q = CFG_W'(ctrl);

    adc_ctrl_reg #(.SAMP_RST(SAMP_RST)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .ctrl(ctrl)
    );

    adc_clk_tick u_tick (
        .clk(clk), .rst_n(rst_n), .full(ctrl.clk_full), .run(busy),
        .restart(restart), .tick(tick)
    );

    adc_conv_fsm #(
        .CH_W(CH_W), .RES_W(RES_W), .SAR_STEPS(SAR_STEPS), .STEP_CYC(STEP_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .tick(tick),
        .trig_valid(trig_valid), .trig_chan(trig_chan), .ovr_clr(ovr_clr),
        .restart(restart), .busy(busy), .done(done), .result(result),
        .overrun(overrun)
    );
endmodule

// File: rtl/adc_conv_sequencer_chk.sv
// Checker: port-level timing properties of the sequencer, bound to the top.
module adc_conv_sequencer_chk
    import adc_seq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_q,
    input logic             ovr_clr,
    input logic             trig_valid,
    input logic             busy,
    input logic             done,
    input logic             overrun
);
    // R4: an early command while running leads to overrun or a completion.
    a_r4_early_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && busy && !cfg_q[0]) |=> (overrun || done));

    // R5: overrun holds without a clear.
    a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    // R6: done is a single-cycle pulse following a busy cycle.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R7: clock select does not move while powered up.
    a_r7_clksel_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[0] |=> $stable(cfg_q[1]));

    // R9: no conversion runs while powered down.
    a_r9_pd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[0] |=> !busy);
endmodule

bind adc_conv_sequencer adc_conv_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .ovr_clr(ovr_clr),
    .trig_valid(trig_valid), .busy(busy), .done(done), .overrun(overrun)
);

// File: tb/adc_conv_sequencer_tb_top.sv
module adc_conv_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_wdata = '0;
    logic [9:0]  cfg_q;
    logic        ovr_clr = 1'b0;
    logic        trig_valid = 1'b0;
    logic [4:0]  trig_chan = '0;
    logic        busy, done, overrun;
    logic [11:0] result;

    int n_chk = 0;
    int n_bad = 0;
    int bcnt = 0;
    int dcnt = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    adc_conv_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .ovr_clr(ovr_clr), .trig_valid(trig_valid),
        .trig_chan(trig_chan), .busy(busy), .done(done), .result(result),
        .overrun(overrun)
    );

    // Busy-cycle and done-pulse counters, sampled mid-cycle.
    always @(negedge clk) begin
        if (busy) bcnt <= bcnt + 1;
        if (done) dcnt <= dcnt + 1;
    end

    typedef struct packed {
        logic       full;
        logic [7:0] samp;
        logic [1:0] mode;   // 0 single, 1 chained, 2 early (overrun)
        logic [4:0] chan;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 8'd22, 2'd0, 5'd3},
        '{1'b1, 8'd22, 2'd1, 5'd7},
        '{1'b0, 8'd4,  2'd0, 5'd12},
        '{1'b0, 8'd4,  2'd1, 5'd20},
        '{1'b1, 8'd22, 2'd2, 5'd9},
        '{1'b1, 8'd0,  2'd0, 5'd31}
    };

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(logic pd, logic full, logic [7:0] s);
        cfg_we = 1'b1;
        cfg_wdata = {s, full, pd};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fire(logic [4:0] ch);
        trig_valid = 1'b1;
        trig_chan = ch;
        @(negedge clk);
        trig_valid = 1'b0;
    endtask

    task automatic clr_cnt();
        @(posedge clk);
        #2;
        bcnt = 0;
        dcnt = 0;
    endtask

    task automatic clr_ovr();
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 overrun", overrun, 0);
        check("R1 cfg", cfg_q, {8'd22, 1'b0, 1'b1});

        // Table walk: R2, R3, R4, R6, R8
        for (int i = 0; i < 6; i++) begin
            vec_t v = VECS[i];
            int d = v.full ? 1 : 2;
            int l1 = (int'(v.samp) + 60) * d;
            int l2 = (int'(v.samp) + 59) * d;
            wr_cfg(1'b1, v.full, v.samp);
            wr_cfg(1'b1, v.full, v.samp);
            wr_cfg(1'b0, v.full, v.samp);
            clr_cnt();
            @(negedge clk);
            fire(v.chan);
            if (v.mode == 2'd1) begin
                repeat (l1 - 1) @(negedge clk);
                fire(v.chan + 5'd1);
            end else if (v.mode == 2'd2) begin
                repeat (l1 - 2) @(negedge clk);
                fire(v.chan + 5'd1);
            end
            repeat (l2 + 10) @(negedge clk);
            if (v.mode == 2'd1) begin
                check("R3 chained busy cycles", bcnt, l1 + l2);
                check("R6 chained done count", dcnt, 2);
                check("R6 chained result", result, int'(v.chan + 5'd1));
                check("R3 no overrun", overrun, 0);
            end else if (v.mode == 2'd2) begin
                check("R4 busy cycles", bcnt, l1);
                check("R4 done count", dcnt, 1);
                check("R4 result of first", result, int'(v.chan));
                check("R4 overrun", overrun, 1);
                clr_ovr();
            end else begin
                check(v.full ? "R2 busy cycles" : "R8 half-clock busy cycles", bcnt, l1);
                check("R6 done count", dcnt, 1);
                check("R6 result", result, int'(v.chan));
                check("R2 no overrun", overrun, 0);
            end
        end

        // R5: overrun sticky, then cleared
        wr_cfg(1'b0, 1'b1, 8'd2);
        fire(5'd1);
        repeat (5) @(negedge clk);
        fire(5'd2);
        repeat (100) @(negedge clk);
        check("R5 overrun held", overrun, 1);
        clr_ovr();
        check("R5 overrun cleared", overrun, 0);

        // R7: clock-select write ignored while powered up (currently 1)
        wr_cfg(1'b0, 1'b0, 8'd2);
        check("R7 clksel locked", cfg_q[1], 1);
        wr_cfg(1'b1, 1'b0, 8'd2);
        check("R7 clksel locked in pd-entry cycle", cfg_q[1], 1);
        wr_cfg(1'b1, 1'b0, 8'd2);
        check("R7 clksel written in pd", cfg_q[1], 0);

        // R9: trigger during power-down ignored
        clr_cnt();
        @(negedge clk);
        fire(5'd4);
        repeat (200) @(negedge clk);
        check("R9 no busy", bcnt, 0);
        check("R9 no done", dcnt, 0);
        check("R9 no overrun", overrun, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule